// File: doc/BRIEF.md
# Parity Write-Per-Bit Mask Unit

This block sits in front of a 36-bit memory word made of four data bytes and four parity bits, one parity bit per byte. It sees the memory control strobes as synchronous, active-low samples. When the row strobe goes active, the block takes a four-bit mask from the parity data pins and keeps it for the whole page. Each write in that page then sets the per-bit enables of the parity bits from the mask, the parity column strobe and the write enable. The four data bytes take no mask. Each one is written through its own column strobe.

The controller places the mask on the parity pins in the cycle where the row strobe first reads low. It may drive write data on those pins from the next cycle on. Enables first appear in the cycle after the row edge. In the edge cycle the new mask is not yet in place, and the column strobes must be inactive then anyway. The storage array and the parity arithmetic are outside this block. All pins are plain control and status signals. No port carries a data stream, so no valid/ready handshake is used and there is no back-pressure. A parameter selects a variant without parity, in which the mask is fixed to all ones.

Top module: `wpb_mask_unit`

## Requirements
- R1: After reset, and until a row strobe active edge has been seen and the page has opened, every byte and parity enable is low.
- R2: In the clock cycle where row_n is low and was high in the previous cycle, the unit captures par_pins as the mask. Bit i of par_pins is the parity bit of byte lane i.
- R3: par_we[i] is high only when mask bit i is 1, par_col_n is low, wr_n is low and the page is open. A mask bit of 0 blocks that parity bit.
- R4: Changes on par_pins after the edge cycle do not change the mask. The same mask gates every write of the page.
- R5: byte_we[i] is high exactly when col_n[i] is low, wr_n is low and the page is open. The mask has no effect on it.
- R6: With wr_n high, no enable is asserted, whatever the state of the strobes.
- R7: The page is open only in a cycle where row_n is low and was also low in the previous cycle. No enable is asserted in the edge cycle or while row_n is high.
- R8: With USE_MASK = 0, the mask is all ones, so par_we follows par_col_n and wr_n alone.
- R9: Each new row strobe active edge replaces the mask that the previous page used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | LANES | Column strobe of each data byte lane, active low |
| par_col_n | input | 1 | Column strobe of the parity lane, active low |
| wr_n | input | 1 | Write enable, active low |
| par_pins | input | LANES | Parity data pins; they carry the mask in the row edge cycle |
| byte_we | output | LANES | Write enable of each data byte |
| par_we | output | LANES | Write enable of each parity bit |

## Verification
The hardest case is a page in which par_pins changes between writes. A faulty design would then pick up the new pin value instead of keeping the captured mask. The stimulus lays a fixed mask on the pins in the edge cycle and then drives its complement and random values while the parity strobe and wr_n toggle. Back-to-back pages with differing masks are also exercised, which checks that the edge cycle itself never writes with the stale mask. Random cycles drop and raise row_n at a low rate, so many pages of varied length and mask are covered.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  localparam int unsigned LANES_DEF = 4;

  // Qualify an active-low strobe vector with write enable, page state and a qualifier.
  function automatic logic [LANES_DEF-1:0] gate_lanes(
    input logic [LANES_DEF-1:0] strobe_n,
    input logic [LANES_DEF-1:0] qual,
    input logic                 wr_n,
    input logic                 open
  );
    return (open && !wr_n) ? (~strobe_n & qual) : '0;
  endfunction
endpackage

// File: rtl/wpb_row_track.sv
module wpb_row_track (
  input  logic clk,
  input  logic rst_n,
  input  logic row_n,
  output logic row_fall,
  output logic page_open
);
  logic row_prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_prev_n <= 1'b1;
    else        row_prev_n <= row_n;
  end

  assign row_fall  = row_prev_n & ~row_n;
  assign page_open = ~row_prev_n & ~row_n;
endmodule

// File: rtl/wpb_mask_reg.sv
module wpb_mask_reg #(
  parameter int unsigned LANES    = 4,
  parameter bit          USE_MASK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [LANES-1:0] pins,
  output logic [LANES-1:0] mask
);
  generate
    if (USE_MASK) begin : g_mask
      logic [LANES-1:0] mask_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_r <= '0;
        else if (capture) mask_r <= pins;
      end
      assign mask = mask_r;
    end else begin : g_nomask
      logic unused_in;
      assign unused_in = capture ^ clk ^ rst_n ^ (^pins);
      assign mask = '1;
    end
  endgenerate
endmodule

// File: rtl/wpb_lane_gate.sv
module wpb_lane_gate #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES-1:0] strobe_n,
  input  logic [LANES-1:0] qual,
  input  logic             wr_n,
  input  logic             open,
  output logic [LANES-1:0] we
);
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      we[i] = open & ~wr_n & ~strobe_n[i] & qual[i];
    end
  end
endmodule

// File: rtl/wpb_mask_unit.sv
module wpb_mask_unit #(
  parameter int unsigned LANES    = wpb_pkg::LANES_DEF,
  parameter bit          USE_MASK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_n,
  input  logic [LANES-1:0] col_n,
  input  logic             par_col_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] par_pins,
  output logic [LANES-1:0] byte_we,
  output logic [LANES-1:0] par_we
);
  logic             row_fall;
  logic             page_open;
  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] par_strobe_n;

  assign par_strobe_n = {LANES{par_col_n}};

  wpb_row_track u_row (
    .clk(clk), .rst_n(rst_n), .row_n(row_n),
    .row_fall(row_fall), .page_open(page_open)
  );

  wpb_mask_reg #(.LANES(LANES), .USE_MASK(USE_MASK)) u_mask (
    .clk(clk), .rst_n(rst_n), .capture(row_fall),
    .pins(par_pins), .mask(mask_q)
  );

  wpb_lane_gate #(.LANES(LANES)) u_bytes (
    .strobe_n(col_n), .qual({LANES{1'b1}}), .wr_n(wr_n),
    .open(page_open), .we(byte_we)
  );

  wpb_lane_gate #(.LANES(LANES)) u_par (
    .strobe_n(par_strobe_n), .qual(mask_q), .wr_n(wr_n),
    .open(page_open), .we(par_we)
  );
endmodule

// File: rtl/wpb_mask_chk.sv
module wpb_mask_chk #(
  parameter int unsigned LANES    = 4,
  parameter bit          USE_MASK = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             row_n,
  input logic [LANES-1:0] col_n,
  input logic             par_col_n,
  input logic             wr_n,
  input logic [LANES-1:0] par_pins,
  input logic [LANES-1:0] byte_we,
  input logic [LANES-1:0] par_we,
  input logic [LANES-1:0] mask_q
);
  generate
    if (USE_MASK) begin : g_cap
      // R2
      mask_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(row_n) && !row_n) |=> (mask_q == $past(par_pins)));
      // R4
      mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(row_n) && !row_n) |=> $stable(mask_q));
    end
  endgenerate

  // R3
  par_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((par_we & ~mask_q) == '0) && (par_col_n -> par_we == '0));

  // R5
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we & col_n) == '0);

  // R6
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |-> (byte_we == '0 && par_we == '0));

  // R7
  page_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_n || $past(row_n)) |-> (byte_we == '0 && par_we == '0));
endmodule

bind wpb_mask_unit wpb_mask_chk #(.LANES(LANES), .USE_MASK(USE_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
  .par_col_n(par_col_n), .wr_n(wr_n), .par_pins(par_pins),
  .byte_we(byte_we), .par_we(par_we), .mask_q(mask_q)
);

// File: tb/sim_wpb_mask_unit.sv
module sim_wpb_mask_unit;
  localparam int CLK_PERIOD = 10;
  localparam int L = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         row_n = 1'b1;
  logic [L-1:0] col_n = '1;
  logic         par_col_n = 1'b1;
  logic         wr_n = 1'b1;
  logic [L-1:0] par_pins = '0;
  logic [L-1:0] byte_we, par_we, byte_we1, par_we1;

  int checks = 0;
  int fails  = 0;

  logic [L-1:0] m_mask = '0;
  logic         m_prev_n = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpb_mask_unit #(.LANES(L), .USE_MASK(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
    .par_col_n(par_col_n), .wr_n(wr_n), .par_pins(par_pins),
    .byte_we(byte_we), .par_we(par_we)
  );

  wpb_mask_unit #(.LANES(L), .USE_MASK(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
    .par_col_n(par_col_n), .wr_n(wr_n), .par_pins(par_pins),
    .byte_we(byte_we1), .par_we(par_we1)
  );

  function automatic logic is_open();
    return !row_n && !m_prev_n;
  endfunction

  function automatic logic [L-1:0] exp_byte();
    return (is_open() && !wr_n) ? ~col_n : '0;
  endfunction

  function automatic logic [L-1:0] exp_par(input logic [L-1:0] mk);
    return (is_open() && !wr_n && !par_col_n) ? mk : '0;
  endfunction

  task automatic check(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string rb, input string rp);
    check(rb, byte_we, exp_byte());
    check(rp, par_we, exp_par(m_mask));
    check("R8", par_we1, exp_par('1));
    check(rb, byte_we1, exp_byte());
  endtask

  // Inputs are set at a negedge; check 1 time unit later; model updates at posedge.
  task automatic step(input string rb, input string rp);
    #1 check_all(rb, rp);
    @(posedge clk);
    if (m_prev_n && !row_n) m_mask = par_pins;
    m_prev_n = row_n;
    @(negedge clk);
  endtask

  task automatic drive(input logic r, input logic [L-1:0] c, input logic pc,
                       input logic w, input logic [L-1:0] p);
    row_n = r; col_n = c; par_col_n = pc; wr_n = w; par_pins = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    @(negedge clk);
    @(negedge clk);
    // R1: strobes active during and right after reset, no enables
    drive(1'b0, '0, 1'b0, 1'b0, 4'b1111);
    #1 check("R1", byte_we, '0);
    check("R1", par_we, '0);
    rst_n = 1'b1;
    drive(1'b1, '0, 1'b0, 1'b0, 4'b1111);
    step("R1", "R1");

    // R2/R7: edge cycle with mask 1010, strobes active but page not yet open
    drive(1'b0, '0, 1'b0, 1'b0, 4'b1010);
    step("R7", "R7");
    // R3/R4: pins now carry the complement; mask must stay 1010
    drive(1'b0, '1, 1'b0, 1'b0, 4'b0101);
    step("R5", "R4");
    check("R2", par_we, 4'b1010);
    drive(1'b0, 4'b0110, 1'b0, 1'b0, 4'b1111);
    step("R5", "R3");
    // R6: write enable high blocks everything
    drive(1'b0, '0, 1'b0, 1'b1, 4'b1111);
    step("R6", "R6");
    // R3: parity strobe high blocks parity
    drive(1'b0, '0, 1'b1, 1'b0, 4'b1111);
    step("R5", "R3");
    // close page
    drive(1'b1, '0, 1'b0, 1'b0, 4'b0000);
    step("R7", "R7");
    // R9: new page with mask 0011
    drive(1'b0, '1, 1'b1, 1'b1, 4'b0011);
    step("R7", "R9");
    drive(1'b0, '0, 1'b0, 1'b0, 4'b1100);
    step("R5", "R9");
    check("R9", par_we, 4'b0011);
    // R3: zero mask blocks all parity bits
    drive(1'b1, '1, 1'b1, 1'b1, 4'b0000);
    step("R7", "R7");
    drive(1'b0, '1, 1'b1, 1'b1, 4'b0000);
    step("R7", "R2");
    drive(1'b0, '0, 1'b0, 1'b0, 4'b1111);
    step("R5", "R3");

    // random phase
    for (int n = 0; n < 2000; n++) begin
      logic r;
      r = row_n;
      if (($urandom % 8) == 0) r = ~r;
      drive(r, L'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0, L'($urandom));
      step("R5", "R4");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule